// File: doc/BRIEF.md
# Linked-Descriptor DMA Chaining Controller

This block is the chaining logic for a single DMA channel. It holds the channel's working registers: index, modifier, count and chain pointer. It refills them from four-word descriptors kept in local memory, read through a synchronous read port with one cycle of latency. Each descriptor carries a pointer to its successor, so descriptors form a linked list. A descriptor that points to itself repeats its transfer until software rewrites the chain pointer.

Software sets the chain-enable bit and then writes a descriptor address into the chain pointer. That write starts the first fetch. After the fetch the channel is in its running state, and each transfer strobe from the data mover advances the index by the signed modifier and lowers the count by one. When the count reaches zero, an end check in the following cycle looks at the chain pointer. A nonzero address field with chain enable set starts the next fetch. Otherwise the channel goes idle.

The state machine has five states:
- `ST_IDLE`: leaves for `ST_FETCH` on a chain-pointer write that qualifies.
- `ST_RUN`: leaves for `ST_ENDCHK` when the count runs out.
- `ST_ENDCHK`: goes to `ST_FETCH` if the chain continues, otherwise to `ST_IDLE`.
- `ST_FETCH`: issues four reads, then goes to `ST_TAIL`.
- `ST_TAIL`: takes the last word, then goes to `ST_RUN` if the count is nonzero, otherwise to `ST_ENDCHK`.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset all registers, including chain enable, are zero, the channel is idle, and no status output and no memory read is active.
- R2: Register write selects are 0 = control (bit 0 is chain enable), 1 = count and 2 = chain pointer. A chain-pointer write in idle with chain enable set and a nonzero address field (bits 18:0) starts a fetch. Reads go to address A, A+1, A+2 and A+3 on four consecutive cycles, starting the cycle after the write. The words load, in order, the chain pointer (bits 19:0), the count, the modifier and the index. The channel runs one cycle after the last read.
- R3: A chain-pointer write with chain enable clear, or setting chain enable alone, stores the value but starts no fetch.
- R4: Each transfer strobe while running adds the sign-extended 16-bit modifier to the 19-bit index, modulo 2^19, and lowers the count by one.
- R5: The strobe that brings the count to zero causes `seq_end` high for one cycle starting in the next cycle. If the chain continues, the first read of the next descriptor follows in the cycle after that.
- R6: If the end check sees a zero address field, the channel goes idle and issues no read.
- R7: A chain-pointer write during a running sequence, including one in the same cycle as the final strobe, decides whether and where the chain continues.
- R8: A descriptor whose next pointer holds its own address is fetched and run again after every sequence.
- R9: `chan_active` is low and `desc_busy` is high for the whole fetch. The two are never high together.
- R10: A strobe during a fetch changes no register and raises `xfer_err` for one cycle in the cycle after it.
- R11: Bit 19 of the chain pointer is stored and read back but changes neither the start nor the chaining decision.
- R12: A descriptor with a zero count goes straight from the fetch to the end check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 control, 1 count, 2 chain pointer |
| reg_wr_data | input | 32 | Register write data |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_rd_addr | output | 19 | Descriptor word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| xfer_stb | input | 1 | One transfer completed |
| index_o | output | 19 | Index register |
| modifier_o | output | 16 | Modifier register (signed) |
| count_o | output | 16 | Count register |
| chain_ptr_o | output | 20 | Chain pointer register |
| chain_en_o | output | 1 | Chain enable bit |
| chan_active | output | 1 | A sequence is running |
| desc_busy | output | 1 | A descriptor fetch is in progress |
| seq_end | output | 1 | End-check cycle |
| xfer_err | output | 1 | A strobe arrived during a fetch |

## Verification
The sharpest collision is a chain-pointer write in the same cycle as the strobe that empties the count. The bench drives both on one edge: it clears the pointer while the successor stored in the descriptor is nonzero, and it checks that the end check reads the new value and that no read of the old successor ever appears. A strobe landing inside a fetch is the second overlap. It is judged by the error pulse one cycle later and by the index and count being unchanged once the fetch completes. A scoreboard of expected read addresses catches any read that is extra, out of order or missing.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_ENDCHK = 3'd2,
        ST_FETCH  = 3'd3,
        ST_TAIL   = 3'd4
    } dcc_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CHAIN = 2'd2;

    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned WORD_SEL_W = $clog2(DESC_WORDS);

    // Position of each field inside a descriptor
    localparam logic [WORD_SEL_W-1:0] WORD_NEXT  = 2'd0;
    localparam logic [WORD_SEL_W-1:0] WORD_COUNT = 2'd1;
    localparam logic [WORD_SEL_W-1:0] WORD_MOD   = 2'd2;
    localparam logic [WORD_SEL_W-1:0] WORD_INDEX = 2'd3;

endpackage

// File: rtl/dcc_regs.sv
module dcc_regs
    import dcc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CP_W   = 20,
    parameter int unsigned IDX_W  = 19,
    parameter int unsigned MOD_W  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  fetch_busy,
    input  logic                  load_vld,
    input  logic [WORD_SEL_W-1:0] load_word,
    input  logic [DATA_W-1:0]     load_data,
    input  logic                  step_en,
    output logic                  chain_en,
    output logic [CP_W-1:0]       chain_ptr,
    output logic [CNT_W-1:0]      count,
    output logic [MOD_W-1:0]      modifier,
    output logic [IDX_W-1:0]      index
);

    logic wr_ctrl;
    logic wr_count;
    logic wr_chain;
    logic ld_next;
    logic ld_count;
    logic ld_mod;
    logic ld_index;
    logic [IDX_W-1:0] step_delta;
    wire  unused_hi = ^{wr_data[DATA_W-1:CP_W], load_data[DATA_W-1:CP_W]};

    // Count and chain pointer belong to the fetch while it runs
    assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
    assign wr_count = wr_en && (wr_sel == SEL_COUNT) && !fetch_busy;
    assign wr_chain = wr_en && (wr_sel == SEL_CHAIN) && !fetch_busy;

    assign ld_next  = load_vld && (load_word == WORD_NEXT);
    assign ld_count = load_vld && (load_word == WORD_COUNT);
    assign ld_mod   = load_vld && (load_word == WORD_MOD);
    assign ld_index = load_vld && (load_word == WORD_INDEX);

    assign step_delta = IDX_W'($signed(modifier));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_en <= 1'b0;
        end else if (wr_ctrl) begin
            chain_en <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_ptr <= '0;
        end else if (ld_next) begin
            chain_ptr <= load_data[CP_W-1:0];
        end else if (wr_chain) begin
            chain_ptr <= wr_data[CP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld_count) begin
            count <= load_data[CNT_W-1:0];
        end else if (wr_count) begin
            count <= wr_data[CNT_W-1:0];
        end else if (step_en) begin
            count <= count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modifier <= '0;
        end else if (ld_mod) begin
            modifier <= load_data[MOD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
        end else if (ld_index) begin
            index <= load_data[IDX_W-1:0];
        end else if (step_en) begin
            index <= index + step_delta;
        end
    end

endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
    import dcc_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic                  chain_en,
    input  logic [ADDR_W-1:0]     chain_addr,
    input  logic [CNT_W-1:0]      count,
    input  logic                  xfer_stb,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    output logic                  load_vld,
    output logic [WORD_SEL_W-1:0] load_word,
    output logic                  step_en,
    output logic                  chan_active,
    output logic                  desc_busy,
    output logic                  seq_end,
    output logic                  xfer_err
);

    localparam logic [WORD_SEL_W-1:0] LAST_WORD = WORD_SEL_W'(DESC_WORDS - 1);

    dcc_state_e state_q, state_d;
    logic [WORD_SEL_W-1:0] issue_q;
    logic [ADDR_W-1:0]     base_q;
    logic                  rvld_q;
    logic [WORD_SEL_W-1:0] rword_q;
    logic                  err_q;

    logic busy;
    logic wr_chain_now;
    logic wr_count_now;
    logic [ADDR_W-1:0] addr_eff;
    logic go_chain;
    logic count_out;

    assign busy         = (state_q == ST_FETCH) || (state_q == ST_TAIL);
    assign wr_chain_now = wr_en && (wr_sel == SEL_CHAIN) && !busy;
    assign wr_count_now = wr_en && (wr_sel == SEL_COUNT) && !busy;
    // A write in the deciding cycle counts as already present
    assign addr_eff     = wr_chain_now ? wr_addr : chain_addr;
    assign go_chain     = chain_en && (addr_eff != '0);
    assign step_en      = (state_q == ST_RUN) && xfer_stb && (count != '0);
    assign count_out    = !wr_count_now &&
                          ((count == '0) || (step_en && (count == CNT_W'(1))));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_chain_now && go_chain) state_d = ST_FETCH;
            ST_RUN:    if (count_out) state_d = ST_ENDCHK;
            ST_ENDCHK: state_d = go_chain ? ST_FETCH : ST_IDLE;
            ST_FETCH:  if (issue_q == LAST_WORD) state_d = ST_TAIL;
            ST_TAIL:   state_d = (count != '0) ? ST_RUN : ST_ENDCHK;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Fetch bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q <= '0;
            base_q  <= '0;
            rvld_q  <= 1'b0;
            rword_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if ((state_d == ST_FETCH) && (state_q != ST_FETCH)) begin
                base_q  <= addr_eff;
                issue_q <= '0;
            end else if (state_q == ST_FETCH) begin
                issue_q <= issue_q + WORD_SEL_W'(1);
            end
            rvld_q  <= (state_q == ST_FETCH);
            rword_q <= issue_q;
            err_q   <= busy && xfer_stb;
        end
    end

    // Outputs
    always_comb begin
        mem_rd_en   = (state_q == ST_FETCH);
        mem_rd_addr = base_q + ADDR_W'(issue_q);
        load_vld    = rvld_q;
        load_word   = rword_q;
        chan_active = (state_q == ST_RUN);
        desc_busy   = busy;
        seq_end     = (state_q == ST_ENDCHK);
        xfer_err    = err_q;
    end

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dcc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CP_W   = 20,
    parameter int unsigned IDX_W  = 19,
    parameter int unsigned MOD_W  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_wr_sel,
    input  logic [DATA_W-1:0]   reg_wr_data,
    output logic                mem_rd_en,
    output logic [CP_W-2:0]     mem_rd_addr,
    input  logic [DATA_W-1:0]   mem_rd_data,
    input  logic                xfer_stb,
    output logic [IDX_W-1:0]    index_o,
    output logic [MOD_W-1:0]    modifier_o,
    output logic [CNT_W-1:0]    count_o,
    output logic [CP_W-1:0]     chain_ptr_o,
    output logic                chain_en_o,
    output logic                chan_active,
    output logic                desc_busy,
    output logic                seq_end,
    output logic                xfer_err
);

    localparam int unsigned ADDR_W = CP_W - 1;

    logic                  load_vld;
    logic [WORD_SEL_W-1:0] load_word;
    logic                  step_en;

    dcc_fsm #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_sel      (reg_wr_sel),
        .wr_addr     (reg_wr_data[ADDR_W-1:0]),
        .chain_en    (chain_en_o),
        .chain_addr  (chain_ptr_o[ADDR_W-1:0]),
        .count       (count_o),
        .xfer_stb    (xfer_stb),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .load_vld    (load_vld),
        .load_word   (load_word),
        .step_en     (step_en),
        .chan_active (chan_active),
        .desc_busy   (desc_busy),
        .seq_end     (seq_end),
        .xfer_err    (xfer_err)
    );

    dcc_regs #(
        .DATA_W (DATA_W),
        .CP_W   (CP_W),
        .IDX_W  (IDX_W),
        .MOD_W  (MOD_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_data    (reg_wr_data),
        .fetch_busy (desc_busy),
        .load_vld   (load_vld),
        .load_word  (load_word),
        .load_data  (mem_rd_data),
        .step_en    (step_en),
        .chain_en   (chain_en_o),
        .chain_ptr  (chain_ptr_o),
        .count      (count_o),
        .modifier   (modifier_o),
        .index      (index_o)
    );

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_sel,
    input logic [ADDR_W-1:0] chain_addr,
    input logic [CNT_W-1:0]  count_o,
    input logic              xfer_stb,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              chan_active,
    input logic              desc_busy,
    input logic              seq_end,
    input logic              xfer_err
);

    p_read_in_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (desc_busy && !chan_active));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(1)));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(chan_active && desc_busy));

    p_count_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && xfer_stb && (count_o != '0) && !(reg_wr_en && (reg_wr_sel == 2'd1)))
        |=> (count_o == $past(count_o) - CNT_W'(1)));

    p_err_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_busy && xfer_stb) |=> xfer_err);

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> $past(desc_busy && xfer_stb));

    p_end_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |=> !chan_active);

    p_zero_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && (chain_addr == '0) && !(reg_wr_en && (reg_wr_sel == 2'd2)))
        |=> (!desc_busy && !mem_rd_en));

endmodule

bind dma_chain_ctrl dcc_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_dcc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .chain_addr  (chain_ptr_o[ADDR_W-1:0]),
    .count_o     (count_o),
    .xfer_stb    (xfer_stb),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .chan_active (chan_active),
    .desc_busy   (desc_busy),
    .seq_end     (seq_end),
    .xfer_err    (xfer_err)
);

// File: tb/dma_chain_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chain_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd0;
    logic [31:0] reg_wr_data = '0;
    logic        mem_rd_en;
    logic [18:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        xfer_stb = 1'b0;
    logic [18:0] index_o;
    logic [15:0] modifier_o;
    logic [15:0] count_o;
    logic [19:0] chain_ptr_o;
    logic        chain_en_o;
    logic        chan_active;
    logic        desc_busy;
    logic        seq_end;
    logic        xfer_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] mem [0:255];
    int unsigned exp_q [$];

    always #10 clk = ~clk;

    dma_chain_ctrl u_dma_chain_ctrl (.*);

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every read must match the next expected address
    always @(negedge clk) begin
        if (rst_n && mem_rd_en && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 read order: actual %h expected none", mem_rd_addr);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                if (32'(mem_rd_addr) != e) begin
                    fails++;
                    $display("FAIL R2 read order: actual %h expected %h", mem_rd_addr, e);
                end
            end
        end
    end

    task automatic expect_fetch(input int unsigned a);
        for (int k = 0; k < 4; k++) exp_q.push_back(a + k);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_stb();
        xfer_stb = 1'b1;
        @(negedge clk);
        xfer_stb = 1'b0;
    endtask

    task automatic start_desc(input int unsigned a);
        expect_fetch(a);
        reg_write(2'd2, a);
        chk("R9 busy in fetch", desc_busy, 1);
        chk("R9 inactive in fetch", chan_active, 0);
        repeat (5) @(negedge clk);
    endtask

    task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] cnt,
                            input logic [31:0] md, input logic [31:0] ix);
        mem[a] = nxt; mem[a+1] = cnt; mem[a+2] = md; mem[a+3] = ix;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        put_desc(8'h10, 32'h0,     32'd3, 32'd2,      32'h100);
        put_desc(8'h20, 32'h0,     32'd2, 32'hFFFF,   32'h5);
        put_desc(8'h30, 32'h80040, 32'd1, 32'd1,      32'h200);
        put_desc(8'h40, 32'h0,     32'd1, 32'd0,      32'h300);
        put_desc(8'h50, 32'h0,     32'd2, 32'd1,      32'h0);
        put_desc(8'h60, 32'h40,    32'd1, 32'd1,      32'h0);
        put_desc(8'h70, 32'h70,    32'd1, 32'd4,      32'h10);
        put_desc(8'h80, 32'h0,     32'd0, 32'd1,      32'h7);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 index", 32'(index_o), 0);
        chk("R1 count", 32'(count_o), 0);
        chk("R1 chain", 32'(chain_ptr_o), 0);
        chk("R1 flags", {25'd0, chain_en_o, chan_active, desc_busy, seq_end, xfer_err, mem_rd_en, 1'b0}, 0);

        reg_write(2'd0, 32'd1);
        chk("R3 enable alone no fetch", desc_busy, 0);

        // R2 basic fetch and load order
        start_desc(32'h10);
        chk("R2 active", chan_active, 1);
        chk("R2 count", 32'(count_o), 3);
        chk("R2 modifier", 32'(modifier_o), 2);
        chk("R2 index", 32'(index_o), 32'h100);
        chk("R2 chain", 32'(chain_ptr_o), 0);
        pulse_stb();
        chk("R4 index step", 32'(index_o), 32'h102);
        chk("R4 count step", 32'(count_o), 2);
        pulse_stb();
        pulse_stb();
        chk("R5 seq_end", seq_end, 1);
        chk("R5 count zero", 32'(count_o), 0);
        @(negedge clk);
        chk("R6 idle", {desc_busy, chan_active, seq_end}, 0);

        // R4 negative modifier
        start_desc(32'h20);
        chk("R4 start index", 32'(index_o), 5);
        pulse_stb();
        chk("R4 negative step", 32'(index_o), 4);
        pulse_stb();
        @(negedge clk);
        chk("R6 idle after neg", {desc_busy, chan_active}, 0);

        // R3 and R11
        reg_write(2'd0, 32'd0);
        reg_write(2'd2, 32'h20);
        chk("R3 no fetch when disabled", desc_busy, 0);
        chk("R3 value stored", 32'(chain_ptr_o), 32'h20);
        reg_write(2'd0, 32'd1);
        chk("R3 enabling no fetch", desc_busy, 0);
        reg_write(2'd2, 32'h80000);
        chk("R11 bit19 alone no fetch", desc_busy, 0);
        chk("R11 bit19 stored", 32'(chain_ptr_o), 32'h80000);

        // R5 chain to next descriptor, R11 bit 19 in link
        start_desc(32'h30);
        chk("R11 link readback", 32'(chain_ptr_o), 32'h80040);
        expect_fetch(32'h40);
        pulse_stb();
        chk("R5 end pulse", seq_end, 1);
        @(negedge clk);
        chk("R5 fetch follows", desc_busy, 1);
        repeat (5) @(negedge clk);
        chk("R5 next index", 32'(index_o), 32'h300);
        chk("R5 next active", chan_active, 1);
        pulse_stb();
        @(negedge clk);
        chk("R6 idle after chain", {desc_busy, chan_active}, 0);

        // R7 extend chain during run
        start_desc(32'h50);
        pulse_stb();
        expect_fetch(32'h40);
        reg_write(2'd2, 32'h40);
        chk("R7 chain written", 32'(chain_ptr_o), 32'h40);
        pulse_stb();
        repeat (6) @(negedge clk);
        chk("R7 extended index", 32'(index_o), 32'h300);
        chk("R7 extended active", chan_active, 1);
        pulse_stb();
        @(negedge clk);

        // R7 stop chain in the same cycle as the final strobe
        start_desc(32'h60);
        chk("R7 link present", 32'(chain_ptr_o), 32'h40);
        xfer_stb = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 32'h0;
        @(negedge clk);
        xfer_stb = 1'b0; reg_wr_en = 1'b0;
        chk("R7 same-cycle end", seq_end, 1);
        @(negedge clk);
        chk("R7 same-cycle stop", {desc_busy, chan_active}, 0);
        repeat (3) @(negedge clk);

        // R8 self loop
        expect_fetch(32'h70); expect_fetch(32'h70); expect_fetch(32'h70);
        reg_write(2'd2, 32'h70);
        repeat (5) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk("R8 loop index", 32'(index_o), 32'h10);
            chk("R8 loop active", chan_active, 1);
            pulse_stb();
            repeat (6) @(negedge clk);
        end
        chk("R8 third pass index", 32'(index_o), 32'h10);
        reg_write(2'd2, 32'h0);
        pulse_stb();
        @(negedge clk);
        chk("R8 loop broken", {desc_busy, chan_active}, 0);

        // R10 strobe during fetch
        expect_fetch(32'h10);
        reg_write(2'd2, 32'h10);
        pulse_stb();
        chk("R10 error pulse", xfer_err, 1);
        @(negedge clk);
        chk("R10 error one cycle", xfer_err, 0);
        repeat (3) @(negedge clk);
        chk("R10 count untouched", 32'(count_o), 3);
        chk("R10 index untouched", 32'(index_o), 32'h100);
        pulse_stb(); pulse_stb(); pulse_stb();
        @(negedge clk);

        // R12 zero count descriptor
        expect_fetch(32'h80);
        reg_write(2'd2, 32'h80);
        repeat (5) @(negedge clk);
        chk("R12 straight to end", {chan_active, seq_end}, 2'b01);
        chk("R12 index loaded", 32'(index_o), 7);
        @(negedge clk);
        chk("R12 idle", desc_busy, 0);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing reads: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule